// File: doc/BRIEF.md
# Configurable Three-Input Lookup Logic Cell Array

The block is a row of small logic cells, and each cell is configured from ports. Each cell turns three selectable inputs into one output bit through an 8-bit truth table. Each input has its own two-bit selector. The selector can tie the input low, take the output of the even cell of the cell's pair, take the output of the next cell in the row, or take a per-cell external event line.

The table result then passes through an output stage. The stage can be a straight combinational path, a 2-deep shift register (synchronizer) or a 4-deep shift register (filter). The shift register advances on every system clock, or, when a per-cell bit selects it, only on rising edges of the cell's third input. This gives a fixed delay per output transition. An inverting table whose own output is fed back through the stage therefore oscillates at the stage clock divided by 4 or by 8. A cell can also take its stage clock from another cell's output, so chained cells multiply their division ratios.

Each cell has an enable and a pin-drive gate. The array is `NUM_CELLS` wide, and `NUM_CELLS` must be even.

Top module: `lut_cell_array`

## Requirements
- R1: In bypass mode (mode code 0) an enabled cell outputs `truth[{in2,in1,in0}]` in the same cycle. The table is indexed with in2 as the MSB and in0 as the LSB.
- R2: Selector code 0 forces the input to 0. Code 3 takes the cell's event bit `event_i[cell*3+k]` for input k.
- R3: Selector code 1 (feedback) takes the output of cell `cell & ~1`. Selector code 2 (link) takes the output of cell `(cell+1) mod NUM_CELLS`.
- R4: In synchronizer mode (code 1) the output equals the table value sampled 2 stage ticks earlier.
- R5: In filter mode (codes 2 and 3) the output equals the table value sampled 4 stage ticks earlier.
- R6: With `clk_sel_i` low, every system clock edge is a stage tick. With `clk_sel_i` high, a tick occurs only at an edge where input 2 is 1 and was 0 at the previous edge. Between ticks a clocked output holds its value.
- R7: While a cell's enable is low, its output is 0 and its delay stages are cleared at the next edge.
- R8: Active-low asynchronous reset clears every delay stage, so every output reads 0 after reset.
- R9: `pin_o` of a cell equals its `lut_o` when the cell's `pin_en_i` bit is 1, and is 0 otherwise.
- R10: Truth table 0x01 with input 0 on feedback oscillates with a period of 4 clocks in synchronizer mode and 8 clocks in filter mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | NUM_CELLS | Per-cell enable |
| truth_i | input | NUM_CELLS*8 | Per-cell truth table |
| in_sel_i | input | NUM_CELLS*6 | Per-cell selectors, 2 bits per input |
| stage_mode_i | input | NUM_CELLS*2 | Output stage: 0 bypass, 1 synchronizer, 2/3 filter |
| clk_sel_i | input | NUM_CELLS | 1 selects input 2 rising edges as the stage clock |
| pin_en_i | input | NUM_CELLS | Per-cell pin drive gate |
| event_i | input | NUM_CELLS*3 | Per-cell, per-input event lines |
| lut_o | output | NUM_CELLS | Cell outputs |
| pin_o | output | NUM_CELLS | Gated pin outputs |

## Verification
The bypass result and the enable and pin gates are combinational, so the bench checks them in the same cycle, shortly after it changes the inputs. A synchronizer result is due after the second stage tick and a filter result after the fourth. The bench drives on the falling edge and samples 1 ns after each rising edge. It confirms that the output is still unchanged one tick before the due edge and has changed at the due edge. When input 2 supplies the clock, the bench counts rising edges of input 2 rather than system clock cycles. Oscillation is judged by counting transitions over a fixed number of cycles, so the check does not depend on the starting phase.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
  localparam int TABLE_W = 8;
  localparam int N_IN    = 3;
  localparam int SYNC_D  = 2;
  localparam int FILT_D  = 4;

  typedef enum logic [1:0] {
    SEL_MASK  = 2'd0,
    SEL_FB    = 2'd1,
    SEL_LINK  = 2'd2,
    SEL_EVENT = 2'd3
  } in_sel_e;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_SYNC   = 2'd1,
    MODE_FILT   = 2'd2,
    MODE_FILT_B = 2'd3
  } stage_mode_e;
endpackage

// File: rtl/lut_in_mux.sv
module lut_in_mux
  import lut_cell_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       fb_i,
  input  logic       link_i,
  input  logic       event_i,
  output logic       in_o
);
  always_comb begin
    unique case (in_sel_e'(sel_i))
      SEL_FB:    in_o = fb_i;
      SEL_LINK:  in_o = link_i;
      SEL_EVENT: in_o = event_i;
      default:   in_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lut_out_stage.sv
module lut_out_stage
  import lut_cell_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] mode_i,
  input  logic       clk_sel_i,
  input  logic       in2_i,
  input  logic       d_i,
  output logic       tick_o,
  output logic       q_o
);
  logic [FILT_D-1:0] sr_q;
  logic              in2_q;
  logic              q_sel;

  assign tick_o = clk_sel_i ? (in2_i & ~in2_q) : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      in2_q <= 1'b0;
    end else if (!en_i) begin
      sr_q  <= '0;
      in2_q <= 1'b0;
    end else begin
      in2_q <= in2_i;
      if (tick_o) sr_q <= {sr_q[FILT_D-2:0], d_i};
    end
  end

  // one shift chain; sync taps early, filter taps the end
  always_comb begin
    unique case (stage_mode_e'(mode_i))
      MODE_BYPASS: q_sel = d_i;
      MODE_SYNC:   q_sel = sr_q[SYNC_D-1];
      default:     q_sel = sr_q[FILT_D-1];
    endcase
  end

  assign q_o = en_i & q_sel;
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [TABLE_W-1:0] truth_i,
  input  logic [2*N_IN-1:0]  sel_i,
  input  logic [1:0]         mode_i,
  input  logic               clk_sel_i,
  input  logic               fb_i,
  input  logic               link_i,
  input  logic [N_IN-1:0]    ev_i,
  output logic               out_o,
  output logic               lut_val_o,
  output logic               tick_o
);
  logic [N_IN-1:0] in_vec;

  for (genvar k = 0; k < N_IN; k++) begin : g_in
    lut_in_mux u_mux (
      .sel_i  (sel_i[2*k +: 2]),
      .fb_i   (fb_i),
      .link_i (link_i),
      .event_i(ev_i[k]),
      .in_o   (in_vec[k])
    );
  end

  assign lut_val_o = truth_i[in_vec];

  lut_out_stage u_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .mode_i   (mode_i),
    .clk_sel_i(clk_sel_i),
    .in2_i    (in_vec[2]),
    .d_i      (lut_val_o),
    .tick_o   (tick_o),
    .q_o      (out_o)
  );
endmodule

// File: rtl/lut_cell_array.sv
module lut_cell_array
  import lut_cell_pkg::*;
#(
  parameter int NUM_CELLS = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_CELLS-1:0]         enable_i,
  input  logic [NUM_CELLS*TABLE_W-1:0] truth_i,
  input  logic [NUM_CELLS*2*N_IN-1:0]  in_sel_i,
  input  logic [NUM_CELLS*2-1:0]       stage_mode_i,
  input  logic [NUM_CELLS-1:0]         clk_sel_i,
  input  logic [NUM_CELLS-1:0]         pin_en_i,
  input  logic [NUM_CELLS*N_IN-1:0]    event_i,
  output logic [NUM_CELLS-1:0]         lut_o,
  output logic [NUM_CELLS-1:0]         pin_o
);
  logic [NUM_CELLS-1:0] lut_val;
  logic [NUM_CELLS-1:0] tick;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    localparam int PAIR_EVEN = i - (i % 2);
    localparam int NEXT      = (i + 1) % NUM_CELLS;

    lut_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (enable_i[i]),
      .truth_i  (truth_i[i*TABLE_W +: TABLE_W]),
      .sel_i    (in_sel_i[i*2*N_IN +: 2*N_IN]),
      .mode_i   (stage_mode_i[i*2 +: 2]),
      .clk_sel_i(clk_sel_i[i]),
      .fb_i     (lut_o[PAIR_EVEN]),
      .link_i   (lut_o[NEXT]),
      .ev_i     (event_i[i*N_IN +: N_IN]),
      .out_o    (lut_o[i]),
      .lut_val_o(lut_val[i]),
      .tick_o   (tick[i])
    );
  end

  assign pin_o = lut_o & pin_en_i;
endmodule

// File: rtl/lut_cell_array_chk.sv
module lut_cell_array_chk #(
  parameter int NUM_CELLS = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NUM_CELLS-1:0]   enable_i,
  input logic [NUM_CELLS*2-1:0] stage_mode_i,
  input logic [NUM_CELLS-1:0]   pin_en_i,
  input logic [NUM_CELLS-1:0]   lut_o,
  input logic [NUM_CELLS-1:0]   pin_o,
  input logic [NUM_CELLS-1:0]   lut_val,
  input logic [NUM_CELLS-1:0]   tick
);
  logic [2:0] edges_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              edges_q <= '0;
    else if (edges_q != 3'd7) edges_q <= edges_q + 3'd1;
  end

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_chk
    p_disabled_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i[i] |-> !lut_o[i]);

    p_pin_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pin_o[i] == (lut_o[i] & pin_en_i[i]));

    p_sync_delay_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edges_q >= 3'd3 && stage_mode_i[2*i +: 2] == 2'd1 && enable_i[i]
       && $past(enable_i[i]) && $past(enable_i[i], 2)
       && $past(tick[i]) && $past(tick[i], 2))
      |-> lut_o[i] == $past(lut_val[i], 2));

    p_filter_delay_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edges_q >= 3'd5 && stage_mode_i[2*i+1] && enable_i[i]
       && $past(enable_i[i]) && $past(enable_i[i], 2)
       && $past(enable_i[i], 3) && $past(enable_i[i], 4)
       && $past(tick[i]) && $past(tick[i], 2)
       && $past(tick[i], 3) && $past(tick[i], 4))
      |-> lut_o[i] == $past(lut_val[i], 4));

    p_hold_no_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edges_q >= 3'd2 && enable_i[i] && $past(enable_i[i])
       && stage_mode_i[2*i +: 2] != 2'd0
       && $stable(stage_mode_i[2*i +: 2]) && !$past(tick[i]))
      |-> $stable(lut_o[i]));
  end
endmodule

bind lut_cell_array lut_cell_array_chk #(.NUM_CELLS(NUM_CELLS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .stage_mode_i(stage_mode_i),
  .pin_en_i    (pin_en_i),
  .lut_o       (lut_o),
  .pin_o       (pin_o),
  .lut_val     (lut_val),
  .tick        (tick)
);

// File: tb/tb_lut_cell_array.sv
`timescale 1ns/1ps
module tb_lut_cell_array;
  localparam int N = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] enable = '0;
  logic [N*8-1:0] truth = '0;
  logic [N*6-1:0] in_sel = '0;
  logic [N*2-1:0] mode = '0;
  logic [N-1:0] clk_sel = '0;
  logic [N-1:0] pin_en = '0;
  logic [N*3-1:0] ev = '0;
  logic [N-1:0] lut_o;
  logic [N-1:0] pin_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  lut_cell_array #(.NUM_CELLS(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .truth_i(truth),
    .in_sel_i(in_sel), .stage_mode_i(mode), .clk_sel_i(clk_sel),
    .pin_en_i(pin_en), .event_i(ev), .lut_o(lut_o), .pin_o(pin_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cfg(input int c, input logic en, input logic [7:0] tt,
                     input logic [1:0] s0, input logic [1:0] s1, input logic [1:0] s2,
                     input logic [1:0] md, input logic cs, input logic pe);
    enable[c]        = en;
    truth[c*8 +: 8]  = tt;
    in_sel[c*6 +: 6] = {s2, s1, s0};
    mode[c*2 +: 2]   = md;
    clk_sel[c]       = cs;
    pin_en[c]        = pe;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic to_neg();
    @(negedge clk);
  endtask

  task automatic quiesce();
    to_neg();
    enable = '0; ev = '0; clk_sel = '0; mode = '0; pin_en = '0;
    edges(1);
    to_neg();
  endtask

  task automatic t_reset();
    chk("R8 reset out0", lut_o[0], 1'b0);
    chk("R8 reset out1", lut_o[1], 1'b0);
    // mid-run reset clears a loaded stage
    to_neg();
    cfg(0, 1, 8'hFF, 0, 0, 0, 2'd1, 0, 0);
    edges(3);
    chk("R4 sync loaded", lut_o[0], 1'b1);
    to_neg(); rst_n = 1'b0; #1;
    to_neg(); cfg(0, 1, 8'h00, 0, 0, 0, 2'd1, 0, 0); rst_n = 1'b1; #1;
    chk("R8 cleared by reset", lut_o[0], 1'b0);
    quiesce();
  endtask

  task automatic t_bypass_table();
    logic [7:0] tt = 8'b1001_0110 ^ 8'h21;
    cfg(0, 1, tt, 2'd3, 2'd3, 2'd3, 2'd0, 0, 0);
    for (int p = 0; p < 8; p++) begin
      ev[2:0] = p[2:0];
      #1;
      chk("R1 R2 bypass index", lut_o[0], tt[p]);
    end
    ev = '0;
    quiesce();
  endtask

  task automatic t_masked();
    cfg(0, 1, 8'h01, 2'd0, 2'd0, 2'd0, 2'd0, 0, 0);
    ev[2:0] = 3'b111;
    #1;
    chk("R2 masked inputs low", lut_o[0], 1'b1);
    quiesce();
  endtask

  task automatic t_sync_delay();
    cfg(0, 1, 8'h02, 2'd3, 2'd0, 2'd0, 2'd1, 0, 0);
    edges(3); to_neg();
    ev[0] = 1'b1;
    edges(1);
    chk("R4 sync not yet", lut_o[0], 1'b0);
    edges(1);
    chk("R4 sync due", lut_o[0], 1'b1);
    to_neg(); ev[0] = 1'b0;
    edges(1);
    chk("R4 sync fall not yet", lut_o[0], 1'b1);
    edges(1);
    chk("R4 sync fall due", lut_o[0], 1'b0);
    quiesce();
  endtask

  task automatic t_filter_delay();
    cfg(0, 1, 8'h02, 2'd3, 2'd0, 2'd0, 2'd2, 0, 0);
    edges(5); to_neg();
    ev[0] = 1'b1;
    edges(3);
    chk("R5 filter not yet", lut_o[0], 1'b0);
    edges(1);
    chk("R5 filter due", lut_o[0], 1'b1);
    quiesce();
  endtask

  task automatic t_osc(input logic [1:0] md, input int span, input string tag);
    int trans = 0;
    logic prev;
    cfg(0, 1, 8'h01, 2'd1, 2'd0, 2'd0, md, 0, 0);
    edges(10);
    prev = lut_o[0];
    for (int c = 0; c < span; c++) begin
      edges(1);
      if (lut_o[0] != prev) trans++;
      prev = lut_o[0];
    end
    n_chk++;
    if (trans != 8) begin
      n_err++;
      $display("FAIL %s: transitions %0d expected 8", tag, trans);
    end
    quiesce();
  endtask

  task automatic t_link_fb();
    // cell0 follows event; cell1 feedback selects cell0 (even of pair)
    cfg(0, 1, 8'h02, 2'd3, 2'd0, 2'd0, 2'd0, 0, 0);
    cfg(1, 1, 8'h02, 2'd1, 2'd0, 2'd0, 2'd0, 0, 0);
    ev[0] = 1'b1; #1;
    chk("R3 feedback to odd cell", lut_o[1], 1'b1);
    ev[0] = 1'b0; #1;
    chk("R3 feedback to odd cell low", lut_o[1], 1'b0);
    // cell0 link selects cell1 (next)
    cfg(1, 1, 8'h02, 2'd3, 2'd0, 2'd0, 2'd0, 0, 0);
    cfg(0, 1, 8'h01, 2'd2, 2'd0, 2'd0, 2'd0, 0, 0);
    ev[3] = 1'b1; #1;
    chk("R3 link inverted", lut_o[0], 1'b0);
    ev[3] = 1'b0; #1;
    chk("R3 link inverted high", lut_o[0], 1'b1);
    quiesce();
  endtask

  task automatic t_in2_clock();
    cfg(0, 1, 8'hAA, 2'd3, 2'd0, 2'd3, 2'd1, 1, 0);
    ev[0] = 1'b1; ev[2] = 1'b0;
    edges(4);
    chk("R6 no tick no change", lut_o[0], 1'b0);
    to_neg(); ev[2] = 1'b1;
    to_neg(); ev[2] = 1'b0;
    edges(2);
    chk("R6 one tick only", lut_o[0], 1'b0);
    to_neg(); ev[2] = 1'b1;
    edges(1);
    chk("R6 second tick due", lut_o[0], 1'b1);
    quiesce();
  endtask

  task automatic t_enable_clear();
    cfg(0, 1, 8'hFF, 2'd0, 2'd0, 2'd0, 2'd1, 0, 0);
    edges(3);
    chk("R4 sync high", lut_o[0], 1'b1);
    to_neg(); enable[0] = 1'b0; #1;
    chk("R7 disabled low", lut_o[0], 1'b0);
    to_neg(); enable[0] = 1'b1;
    edges(1);
    chk("R7 stages cleared", lut_o[0], 1'b0);
    edges(1);
    chk("R7 refill", lut_o[0], 1'b1);
    quiesce();
  endtask

  task automatic t_pin();
    cfg(0, 1, 8'h01, 2'd0, 2'd0, 2'd0, 2'd0, 0, 0);
    #1;
    chk("R9 pin gated", pin_o[0], 1'b0);
    pin_en[0] = 1'b1; #1;
    chk("R9 pin driven", pin_o[0], 1'b1);
    quiesce();
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    edges(2);
    to_neg(); rst_n = 1'b1;
    edges(1);
    t_reset();
    t_bypass_table();
    t_masked();
    t_sync_delay();
    t_filter_delay();
    t_osc(2'd1, 16, "R10 sync osc");
    t_osc(2'd2, 32, "R10 filter osc");
    t_link_fb();
    t_in2_clock();
    t_enable_clear();
    t_pin();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule